// File: doc/BRIEF.md
# Dual-Mode Video/Transport Character Encoder

This block prepares one 10-bit character per clock for a downstream serializer that shifts out ten bits per character. The clock runs at the character rate, one tenth of the serial line rate. Every input is captured in an input stage on the rising edge. One edge later the encoded result lands in an output register that feeds the serializer.

A registered mode select picks the path for each character. With the select high, all ten bits go LSB first through a self-synchronizing scrambler with polynomial x^9 + x^4 + 1 and then through an NRZI stage (x + 1). Both the scrambler history and the NRZI level carry from one word to the next. With the select low, the word is a transport byte. Bits 8..1 pass through unchanged. Bit 0 becomes the special-character flag and bit 9 becomes the violation-symbol flag, and each flag is forced low unless its own enable is high. A registered valid output goes with every word. An output-enable input floats all outputs when it is low.

Top module: `scramble_pass_encoder`

## Requirements
- R1: While reset is asserted, dout and valid_out read 0 (with oe high). Reset also clears the scrambler history and the NRZI level, so a stream of zero words in scramble mode then encodes to all zeros.
- R2: A word presented before rising edge k reaches dout after rising edge k+1. After edge k alone, dout still shows the previous result.
- R3: In scramble mode each bit i, taken in order 0..9, gives s = d[i] ^ h[8] ^ h[3], where h[0] is the most recent scrambled bit. The history then shifts in s, and the NRZI level becomes level ^ s. Output bit i is the new NRZI level. History and level carry across words.
- R4: In scramble mode valid_out is 1 regardless of valid_in.
- R5: In pass mode dout[8:1] equals din[8:1] of the captured word.
- R6: In pass mode dout[0] equals din[0] when sc_en is 1, and is 0 when sc_en is 0.
- R7: In pass mode dout[9] equals din[9] when viol_en is 1, and is 0 when viol_en is 0.
- R8: In pass mode valid_out equals the captured valid_in.
- R9: A pass-mode word leaves the scrambler history and the NRZI level unchanged, so the scramble stream resumes as if the pass words were absent.
- R10: With oe low, dout and valid_out are high impedance, and the pipeline keeps running. With oe high, they drive the registered values.
- R11: The mode select pass_n is active low: 0 selects pass mode and 1 selects scramble mode. It is sampled on the rising edge together with the data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pass_n | input | 1 | Mode select: 0 pass, 1 scramble |
| sc_en | input | 1 | Lets din[0] through as the special-character flag in pass mode |
| viol_en | input | 1 | Lets din[9] through as the violation flag in pass mode |
| valid_in | input | 1 | Word-valid marker used in pass mode |
| din | input | 10 | Parallel input word |
| oe | input | 1 | Output enable; low floats all outputs |
| dout | output | 10 | Encoded word to the serializer |
| valid_out | output | 1 | Registered word-valid |

## Verification
Two things can happen in the same cycle: the mode select changes, and the scrambler state would advance. A pass word placed between scramble words must freeze the history and the NRZI level while it takes over the output register on that same edge. The vector table interleaves scramble words with pass words that use every flag-enable combination. An independent bit-serial model advances its state only on scramble rows. Each output word is compared against that model, so any state that leaks across a pass word shows up in the next scramble word.

// File: rtl/enc_pkg.sv
package enc_pkg;

  typedef enum logic {
    MODE_PASS = 1'b0,
    MODE_SCR  = 1'b1
  } enc_mode_e;

  localparam int unsigned ENC_WORD_W  = 10;
  localparam int unsigned ENC_SCR_LEN = 9;
  localparam int unsigned ENC_SCR_TAP = 4;

endpackage

// File: rtl/enc_capture.sv
module enc_capture
  import enc_pkg::*;
#(
  parameter int unsigned WORD_W = ENC_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] din,
  input  logic              pass_n,
  input  logic              sc_en,
  input  logic              viol_en,
  input  logic              valid_in,
  output logic [WORD_W-1:0] q_word,
  output enc_mode_e         q_mode,
  output logic              q_sc,
  output logic              q_viol,
  output logic              q_vld
);

  logic [WORD_W-1:0] word_d;
  enc_mode_e         mode_d;
  logic              sc_d, viol_d, vld_d;

  always_comb begin
    word_d = din;
    mode_d = pass_n ? MODE_SCR : MODE_PASS;
    sc_d   = sc_en;
    viol_d = viol_en;
    vld_d  = valid_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_word <= '0;
      q_mode <= MODE_PASS;
      q_sc   <= 1'b0;
      q_viol <= 1'b0;
      q_vld  <= 1'b0;
    end else begin
      q_word <= word_d;
      q_mode <= mode_d;
      q_sc   <= sc_d;
      q_viol <= viol_d;
      q_vld  <= vld_d;
    end
  end

endmodule

// File: rtl/enc_scr_nrzi.sv
module enc_scr_nrzi
  import enc_pkg::*;
#(
  parameter int unsigned WORD_W = ENC_WORD_W,
  parameter int unsigned LEN    = ENC_SCR_LEN,
  parameter int unsigned TAP    = ENC_SCR_TAP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] word_out
);

  localparam int unsigned HI = LEN - 1;
  localparam int unsigned LO = TAP - 1;

  logic [LEN-1:0] hist_q, hist_d, hist_w;
  logic           lvl_q, lvl_d, lvl_w, sbit;

  always_comb begin
    hist_w   = hist_q;
    lvl_w    = lvl_q;
    sbit     = 1'b0;
    word_out = '0;
    for (int i = 0; i < WORD_W; i++) begin
      sbit        = word_in[i] ^ hist_w[HI] ^ hist_w[LO];
      hist_w      = {hist_w[LEN-2:0], sbit};
      lvl_w       = lvl_w ^ sbit;
      word_out[i] = lvl_w;
    end
    hist_d = adv ? hist_w : hist_q;
    lvl_d  = adv ? lvl_w  : lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      lvl_q  <= 1'b0;
    end else begin
      hist_q <= hist_d;
      lvl_q  <= lvl_d;
    end
  end

  // R9
  state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(hist_q) && $stable(lvl_q)));

  // R3
  level_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (lvl_q == $past(word_out[WORD_W-1])));

endmodule

// File: rtl/enc_pass_map.sv
module enc_pass_map
  import enc_pkg::*;
#(
  parameter int unsigned WORD_W = ENC_WORD_W
) (
  input  logic [WORD_W-1:0] word_in,
  input  logic              sc_en,
  input  logic              viol_en,
  output logic [WORD_W-1:0] word_out
);

  for (genvar b = 0; b < WORD_W; b++) begin : g_bit
    if (b == 0) begin : g_sc
      assign word_out[b] = sc_en & word_in[b];
    end else if (b == WORD_W - 1) begin : g_viol
      assign word_out[b] = viol_en & word_in[b];
    end else begin : g_thru
      assign word_out[b] = word_in[b];
    end
  end

endmodule

// File: rtl/scramble_pass_encoder.sv
module scramble_pass_encoder
  import enc_pkg::*;
#(
  parameter int unsigned WORD_W = ENC_WORD_W,
  parameter int unsigned SCR_LEN = ENC_SCR_LEN,
  parameter int unsigned SCR_TAP = ENC_SCR_TAP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pass_n,
  input  logic              sc_en,
  input  logic              viol_en,
  input  logic              valid_in,
  input  logic [WORD_W-1:0] din,
  input  logic              oe,
  output logic [WORD_W-1:0] dout,
  output logic              valid_out
);

  localparam int unsigned MSB = WORD_W - 1;

  logic rst_meta, rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  logic [WORD_W-1:0] cap_word, scr_word, pass_word;
  enc_mode_e         cap_mode;
  logic              cap_sc, cap_viol, cap_vld;

  enc_capture #(.WORD_W(WORD_W)) u_capture (
    .clk      (clk),
    .rst_n    (rst_s),
    .din      (din),
    .pass_n   (pass_n),
    .sc_en    (sc_en),
    .viol_en  (viol_en),
    .valid_in (valid_in),
    .q_word   (cap_word),
    .q_mode   (cap_mode),
    .q_sc     (cap_sc),
    .q_viol   (cap_viol),
    .q_vld    (cap_vld)
  );

  enc_scr_nrzi #(.WORD_W(WORD_W), .LEN(SCR_LEN), .TAP(SCR_TAP)) u_scr (
    .clk      (clk),
    .rst_n    (rst_s),
    .adv      (cap_mode == MODE_SCR),
    .word_in  (cap_word),
    .word_out (scr_word)
  );

  enc_pass_map #(.WORD_W(WORD_W)) u_pass (
    .word_in  (cap_word),
    .sc_en    (cap_sc),
    .viol_en  (cap_viol),
    .word_out (pass_word)
  );

  logic [WORD_W-1:0] out_d, out_q;
  logic              vld_d, vld_q;

  always_comb begin
    if (cap_mode == MODE_SCR) begin
      out_d = scr_word;
      vld_d = 1'b1;
    end else begin
      out_d = pass_word;
      vld_d = cap_vld;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      out_q <= out_d;
      vld_q <= vld_d;
    end
  end

  assign dout      = oe ? out_q : {WORD_W{1'bz}};
  assign valid_out = oe ? vld_q : 1'bz;

  // R5
  mid_bits_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (cap_mode == MODE_PASS) |=> (out_q[MSB-1:1] == $past(cap_word[MSB-1:1])));

  // R6
  sc_gate_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (cap_mode == MODE_PASS && !cap_sc) |=> !out_q[0]);

  // R7
  viol_gate_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (cap_mode == MODE_PASS && !cap_viol) |=> !out_q[MSB]);

  // R4
  scr_valid_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (cap_mode == MODE_SCR) |=> vld_q);

  // R8
  pass_valid_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (cap_mode == MODE_PASS) |=> (vld_q == $past(cap_vld)));

endmodule

// File: tb/scramble_pass_encoder_bench.sv
module scramble_pass_encoder_bench;

  logic       clk = 1'b0;
  logic       rst_n, pass_n, sc_en, viol_en, valid_in, oe;
  logic [9:0] din;
  logic [9:0] dout;
  logic       valid_out;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  scramble_pass_encoder u_scramble_pass_encoder (
    .clk       (clk),
    .rst_n     (rst_n),
    .pass_n    (pass_n),
    .sc_en     (sc_en),
    .viol_en   (viol_en),
    .valid_in  (valid_in),
    .din       (din),
    .oe        (oe),
    .dout      (dout),
    .valid_out (valid_out)
  );

  // row: {pass_n, sc_en, viol_en, valid_in, din[9:0]}
  localparam int N = 18;
  localparam logic [13:0] VEC [N] = '{
    {4'b1000, 10'h3FF},
    {4'b1000, 10'h000},
    {4'b1001, 10'h155},
    {4'b0001, 10'h3FF},
    {4'b0101, 10'h3FF},
    {4'b0010, 10'h3FF},
    {4'b0111, 10'h201},
    {4'b1000, 10'h2AA},
    {4'b1001, 10'h001},
    {4'b0111, 10'h0A4},
    {4'b1000, 10'h200},
    {4'b1000, 10'h3C3},
    {4'b0000, 10'h000},
    {4'b1000, 10'h000},
    {4'b1001, 10'h07E},
    {4'b1000, 10'h3FF},
    {4'b0000, 10'h000},
    {4'b0000, 10'h000}
  };

  logic [8:0] m_hist;
  logic       m_lvl;

  task automatic model(input logic [13:0] r, output logic [9:0] e, output logic ev);
    logic s;
    if (r[13]) begin
      for (int i = 0; i < 10; i++) begin
        s      = r[i] ^ m_hist[8] ^ m_hist[3];
        m_hist = {m_hist[7:0], s};
        m_lvl  = m_lvl ^ s;
        e[i]   = m_lvl;
      end
      ev = 1'b1;
    end else begin
      e     = r[9:0];
      e[0]  = r[9] ? 1'b0 : 1'b0;
      e[0]  = r[12] & r[0];
      e[9]  = r[11] & r[9];
      ev    = r[10];
    end
  endtask

  task automatic drive(input logic [13:0] r);
    pass_n   = r[13];
    sc_en    = r[12];
    viol_en  = r[11];
    valid_in = r[10];
    din      = r[9:0];
  endtask

  task automatic chk(input string req, input logic [9:0] got, input logic [9:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  logic [9:0] exp_w [N];
  logic       exp_v [N];

  initial begin
    logic [9:0] ew;
    logic       ev;
    rst_n = 1'b0;
    oe    = 1'b1;
    drive(14'h0);
    m_hist = '0;
    m_lvl  = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state at the outputs
    chk("R1 dout in reset", dout, 10'h000);
    chk("R1 valid_out in reset", {9'b0, valid_out}, 10'h000);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // vector table
    for (int i = 0; i < N; i++) begin
      if (i >= 2) begin
        if (VEC[i-2][13]) begin
          chk("R3 R9 scrambled word", dout, exp_w[i-2]);
          chk("R4 valid in scramble mode", {9'b0, valid_out}, {9'b0, exp_v[i-2]});
        end else begin
          chk("R5 R6 R7 R11 pass word", dout, exp_w[i-2]);
          chk("R8 valid in pass mode", {9'b0, valid_out}, {9'b0, exp_v[i-2]});
        end
      end
      drive(VEC[i]);
      model(VEC[i], exp_w[i], exp_v[i]);
      @(negedge clk);
    end
    repeat (2) @(negedge clk);

    // R2: latency
    drive({4'b0001, 10'h0F0});
    @(negedge clk);
    chk("R2 output not yet updated", dout, 10'h000);
    chk("R2 valid not yet updated", {9'b0, valid_out}, 10'h000);
    drive(14'h0);
    @(negedge clk);
    chk("R2 output after second edge", dout, 10'h0F0);
    chk("R2 valid after second edge", {9'b0, valid_out}, 10'h001);

    // R10: outputs float while the pipeline keeps running
    oe = 1'b0;
    drive({4'b1000, 10'h155});
    model({4'b1000, 10'h155}, ew, ev);
    #1;
    n_chk++;
    if (dout !== 10'bz || valid_out !== 1'bz) begin
      n_err++;
      $display("FAIL R10: got %h/%b expected z", dout, valid_out);
    end
    @(negedge clk);
    drive(14'h0);
    @(negedge clk);
    n_chk++;
    if (dout !== 10'bz || valid_out !== 1'bz) begin
      n_err++;
      $display("FAIL R10: got %h/%b expected z", dout, valid_out);
    end
    oe = 1'b1;
    #1;
    chk("R10 word produced while floating", dout, ew);
    chk("R10 R4 valid produced while floating", {9'b0, valid_out}, 10'h001);

    // R1: reset in mid-stream clears state
    @(negedge clk);
    rst_n = 1'b0;
    drive({4'b1000, 10'h000});
    m_hist = '0;
    m_lvl  = 1'b0;
    #1;
    chk("R1 dout on mid-stream reset", dout, 10'h000);
    chk("R1 valid_out on mid-stream reset", {9'b0, valid_out}, 10'h000);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 zero stream after reset", dout, 10'h000);
    chk("R1 R4 valid after reset", {9'b0, valid_out}, 10'h001);
    drive({4'b1000, 10'h3FF});
    model({4'b1000, 10'h3FF}, ew, ev);
    @(negedge clk);
    drive({4'b0000, 10'h000});
    @(negedge clk);
    chk("R1 R3 first word from cleared state", dout, ew);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule